// File: doc/BRIEF.md
# Chroma Line Delay

This block delays two baseband colour-difference sample streams, R-Y and B-Y, by exactly one line. A clock enable from the master oscillator is divided by six to form a sample strobe. On each strobe, one 8-bit sample per channel enters a fixed-length shift register, and the sample stored one line earlier leaves it. Both channels share the same strobe and storage control.

Storage is limited to the active part of each line. A one-cycle active-start pulse from the line timing decoder resets the divider phase and the sample count. The block then takes a fixed number of samples and stops, holding its contents through blanking. While delayed samples from a complete earlier line are being presented, the output is flagged valid. At all other times both outputs carry a fixed black-level code.

Top module: `chroma_line_delay`

## Requirements
- R1: With the default length of 166, the sample output after the k-th strobe of a line equals, on each channel, the input sample taken 166 strobes earlier, with R-Y and B-Y kept in step. Between strobes the output holds.
- R2: The strobe fires on every sixth cycle in which `mclk_en_i` is high. The first strobe comes on the first enabled cycle after the active-start cycle. Cycles with `mclk_en_i` low neither advance the phase nor move the output.
- R3: `act_start_i` resets the divider phase and the sample count. If it arrives on a cycle that would have been a strobe, the restart takes precedence and no sample is taken on that cycle.
- R4: After 166 strobes in a line, no further samples are taken until the next `act_start_i`, whatever `mclk_en_i` and the inputs do. The stored contents are held unchanged.
- R5: `valid_o` goes high at a strobe only once a complete line has been stored. It drops one strobe period after the 166th strobe and in the cycle after `act_start_i`. While it is low, both `ry_o` and `by_o` equal `BLACK_CODE` (default 8'h80).
- R6: After reset, `valid_o` stays low through the whole of the first line, because no earlier line has been stored.
- R7: During and right after reset, `valid_o` is 0 and both outputs show `BLACK_CODE`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mclk_en_i | input | 1 | Master clock enable counted by the divide-by-six |
| act_start_i | input | 1 | One-cycle pulse marking the start of active video |
| ry_i | input | 8 | R-Y sample input |
| by_i | input | 8 | B-Y sample input |
| ry_o | output | 8 | Delayed R-Y sample, or black code when not valid |
| by_o | output | 8 | Delayed B-Y sample, or black code when not valid |
| valid_o | output | 1 | High while delayed samples of a stored line are shown |

## Verification
Two events can fall on the same cycle: the active-start pulse and a strobe slot of a line still in progress. The bench provokes this by cutting a line short after 60 samples and raising the next active-start exactly on the cycle when the 61st strobe is due. The test passes only if no sample is taken on that cycle and the output turns black. The bench also checks that the following lines deliver what a 166-deep model predicts from the true strobe history.

// File: rtl/chroma_dly_pkg.sv
`timescale 1ns/1ps
package chroma_dly_pkg;
  parameter int unsigned SMP_W = 8;

  typedef struct packed {
    logic [SMP_W-1:0] ry;
    logic [SMP_W-1:0] by;
  } chroma_t;
endpackage

// File: rtl/chroma_strobe_gen.sv
`timescale 1ns/1ps
module chroma_strobe_gen #(
  parameter int unsigned DIV      = 6,
  parameter int unsigned LINE_LEN = 166
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic mclk_en_i,
  input  logic act_start_i,
  output logic shift_o,
  output logic line_end_o,
  output logic filled_o
);
  localparam int unsigned DIV_W = $clog2(DIV);
  localparam int unsigned CNT_W = $clog2(LINE_LEN + 1);

  logic             active_q;
  logic             filled_q;
  logic [DIV_W-1:0] div_q;
  logic [CNT_W-1:0] cnt_q;
  logic             slot;
  logic             cnt_done;

  assign cnt_done = (cnt_q == CNT_W'(LINE_LEN));
  // restart beats a coincident strobe slot
  assign slot       = active_q && mclk_en_i && (div_q == '0) && !act_start_i;
  assign shift_o    = slot && !cnt_done;
  assign line_end_o = slot && cnt_done;
  assign filled_o   = filled_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      filled_q <= 1'b0;
      div_q    <= '0;
      cnt_q    <= '0;
    end else if (act_start_i) begin
      active_q <= 1'b1;
      div_q    <= '0;
      cnt_q    <= '0;
    end else if (active_q && mclk_en_i) begin
      div_q <= (div_q == DIV_W'(DIV - 1)) ? '0 : div_q + 1'b1;
      if (div_q == '0) begin
        if (cnt_done) begin
          active_q <= 1'b0;
          filled_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  a_r2_strobe_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_o |=> !shift_o && !line_end_o);
  a_r4_count_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(LINE_LEN));
  a_r4_idle_no_shift: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_end_o |=> !shift_o);
endmodule

// File: rtl/chroma_line_store.sv
`timescale 1ns/1ps
module chroma_line_store
  import chroma_dly_pkg::*;
#(
  parameter int unsigned LINE_LEN = 166
) (
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    shift_i,
  input  chroma_t din_i,
  output chroma_t tail_o
);
  chroma_t sr_q [LINE_LEN];

  for (genvar i = 0; i < LINE_LEN; i++) begin : g_cell
    if (i == 0) begin : g_head
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)      sr_q[i] <= '0;
        else if (shift_i) sr_q[i] <= din_i;
      end
    end else begin : g_body
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)      sr_q[i] <= '0;
        else if (shift_i) sr_q[i] <= sr_q[i-1];
      end
    end
  end

  assign tail_o = sr_q[LINE_LEN-1];

  a_r4_hold_contents: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !shift_i |=> $stable(tail_o));
endmodule

// File: rtl/chroma_line_delay.sv
`timescale 1ns/1ps
module chroma_line_delay
  import chroma_dly_pkg::*;
#(
  parameter int unsigned        DIV        = 6,
  parameter int unsigned        LINE_LEN   = 166,
  parameter logic [SMP_W-1:0]   BLACK_CODE = 8'h80
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             mclk_en_i,
  input  logic             act_start_i,
  input  logic [SMP_W-1:0] ry_i,
  input  logic [SMP_W-1:0] by_i,
  output logic [SMP_W-1:0] ry_o,
  output logic [SMP_W-1:0] by_o,
  output logic             valid_o
);
  logic    shift;
  logic    line_end;
  logic    filled;
  chroma_t din;
  chroma_t tail;
  chroma_t out_q;
  logic    valid_q;

  assign din.ry = ry_i;
  assign din.by = by_i;

  chroma_strobe_gen #(.DIV(DIV), .LINE_LEN(LINE_LEN)) i_strobe (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .mclk_en_i  (mclk_en_i),
    .act_start_i(act_start_i),
    .shift_o    (shift),
    .line_end_o (line_end),
    .filled_o   (filled)
  );

  chroma_line_store #(.LINE_LEN(LINE_LEN)) i_store (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .shift_i(shift),
    .din_i  (din),
    .tail_o (tail)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q   <= '0;
      valid_q <= 1'b0;
    end else if (act_start_i) begin
      valid_q <= 1'b0;
    end else if (shift) begin
      out_q   <= tail;
      valid_q <= filled;
    end else if (line_end) begin
      valid_q <= 1'b0;
    end
  end

  assign ry_o    = valid_q ? out_q.ry : BLACK_CODE;
  assign by_o    = valid_q ? out_q.by : BLACK_CODE;
  assign valid_o = valid_q;

  a_r5_start_blanks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_start_i |=> !valid_o);
  a_r6_no_valid_before_fill: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !filled |-> !valid_o);
  a_r1_hold_between: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !shift && !act_start_i && !line_end |=> $stable(ry_o) && $stable(by_o));
endmodule

// File: tb/test_chroma_line_delay.sv
`timescale 1ns/1ps
module test_chroma_line_delay;
  localparam int LEN = 166;
  localparam logic [7:0] BLACK = 8'h80;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic       act = 1'b0;
  logic [7:0] ry_in = '0;
  logic [7:0] by_in = '0;
  logic [7:0] ry_out;
  logic [7:0] by_out;
  logic       vld;

  int checks = 0;
  int errors = 0;

  logic [7:0]  m_ry [LEN];
  logic [7:0]  m_by [LEN];
  logic        m_filled = 1'b0;
  logic [16:0] cur_exp;

  always #2.5 clk = ~clk;

  chroma_line_delay i_chroma_line_delay (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .mclk_en_i  (en),
    .act_start_i(act),
    .ry_i       (ry_in),
    .by_i       (by_in),
    .ry_o       (ry_out),
    .by_o       (by_out),
    .valid_o    (vld)
  );

  task automatic chk(string req);
    checks++;
    if ({vld, ry_out, by_out} !== cur_exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, {vld, ry_out, by_out}, cur_exp);
    end
  endtask

  function automatic logic [7:0] pat_ry(int id, int k);
    return 8'(id * 41 + k * 3 + 7);
  endfunction

  function automatic logic [7:0] pat_by(int id, int k);
    return 8'((id * 13) ^ (k * 5));
  endfunction

  // model of one strobe: output takes the sample 166 strobes old
  task automatic model_strobe(logic [7:0] r, logic [7:0] b);
    cur_exp = m_filled ? {1'b1, m_ry[LEN-1], m_by[LEN-1]} : {1'b0, BLACK, BLACK};
    for (int i = LEN - 1; i > 0; i--) begin
      m_ry[i] = m_ry[i-1];
      m_by[i] = m_by[i-1];
    end
    m_ry[0] = r;
    m_by[0] = b;
  endtask

  // called at a negedge; returns at the negedge right before the next slot
  task automatic run_line(int id, int n, int gap, string req);
    act = 1'b1;
    en  = 1'b1;
    @(negedge clk);
    act = 1'b0;
    cur_exp = {1'b0, BLACK, BLACK};
    chk("R5 start blanks");
    for (int k = 0; k < n; k++) begin
      ry_in = pat_ry(id, k);
      by_in = pat_by(id, k);
      en = 1'b1;
      @(negedge clk);
      model_strobe(pat_ry(id, k), pat_by(id, k));
      chk(req);
      ry_in = ~ry_in;
      by_in = by_in + 8'd99;
      for (int g = 0; g < gap; g++) begin
        en = 1'b0;
        @(negedge clk);
        chk("R2 disabled cycle holds");
      end
      en = 1'b1;
      for (int w = 0; w < 5; w++) begin
        @(negedge clk);
        chk("R2 hold between strobes");
      end
    end
    if (n == LEN) begin
      @(negedge clk);
      cur_exp  = {1'b0, BLACK, BLACK};
      m_filled = 1'b1;
      chk("R5 end of line blanks");
    end
  endtask

  task automatic blank(int n);
    en = 1'b1;
    for (int i = 0; i < n; i++) begin
      ry_in = 8'(i * 7 + 3);
      by_in = 8'(i * 11 + 1);
      @(negedge clk);
      chk("R4 no sampling in blanking");
    end
  endtask

  initial begin
    for (int i = 0; i < LEN; i++) begin
      m_ry[i] = '0;
      m_by[i] = '0;
    end
    cur_exp = {1'b0, BLACK, BLACK};
    repeat (3) @(negedge clk);
    chk("R7 reset state");
    rst_n = 1'b1;
    @(negedge clk);
    chk("R7 after reset");
    blank(8);
    run_line(0, LEN, 0, "R6 first line invalid");
    blank(20);
    run_line(1, LEN, 0, "R1 one line delay");
    blank(10);
    run_line(2, LEN, 3, "R2 divider counts enables only");
    blank(5);
    run_line(3, 60, 0, "R1 line before restart");
    run_line(4, LEN, 0, "R3 restart on strobe slot");
    blank(12);
    run_line(5, LEN, 1, "R1 delay after restart");
    blank(4);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule